// File: doc/BRIEF.md
# Single-Channel Block-Move DMA Engine with Chained Bus Grant

This engine copies a run of bytes between memory and one peripheral so the processor does not have to. Software writes a start address, a byte count and a control word through a small write port. The control word sets the direction, the interrupt enable and the tenure mode, and carries a start bit. The engine then asks for the shared bus on its request line. It waits for a grant that is passed down a chain of masters, and it holds a busy line for as long as it owns the bus. While it owns the bus, it moves one byte per clock.

Two tenure modes are provided. In burst-steal mode the engine gives up the bus after at most `BURST` bytes and asks for it again. In block mode it keeps the bus until the whole count is done. A grant that reaches the engine while it has no work is passed straight on to the next master in the chain. When the count reaches zero, a done flag is set and a pending interrupt is recorded. The interrupt reaches the output only while the enable bit is set.

Top module: `dma_chan`

## Requirements
- R1: After reset, `br_o`, `bbsy_o`, `xfer_en`, `done_o` and `irq_o` are all 0.
- R2: Write select 0 loads the start address and select 1 loads the byte count. Control (select 2) bits are: bit0 start, bit1 interrupt enable, bit2 direction (1 means memory to device, shown on `xfer_to_dev`), bit3 mode (1 means block, 0 means burst-steal).
- R3: A start moves exactly the programmed number of bytes, one per cycle with `xfer_en` high. The byte addresses run upward from the start address, one step per byte, and `rem_cnt` drops by one per byte.
- R4: The engine begins a tenure (raises `bbsy_o`) only after a cycle in which `bg_i` is 1 and `bbsy_i` is 0. It drops `br_o` when it raises `bbsy_o`, and the two are never high together.
- R5: `bg_o` follows `bg_i` while the engine has no transfer in progress. It is 0 while a transfer is pending or running.
- R6: In burst-steal mode each tenure carries at most `BURST` (default 4) bytes. A 10-byte move therefore takes tenures of 4, 4 and 2 bytes.
- R7: In block mode the whole count moves in a single tenure.
- R8: When the last byte moves, `done_o` rises. `irq_o` is the pending interrupt gated by the enable bit. With enable 0 it stays 0, and a later control write with enable 1 and no start makes it visible.
- R9: A start clears `done_o` and `irq_o`. A start with count 0 sets `done_o` (and the pending interrupt) at once and moves no bytes.
- R10: While a transfer is in progress, writes to the address and count selects and further start bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | WDW | Write data |
| bg_i | input | 1 | Bus grant in from upstream |
| bbsy_i | input | 1 | Bus busy driven by other masters |
| br_o | output | 1 | Bus request |
| bg_o | output | 1 | Bus grant passed downstream |
| bbsy_o | output | 1 | Bus busy, this engine is master |
| xfer_en | output | 1 | One byte moves this cycle |
| xfer_addr | output | AW | Memory address of the current byte |
| xfer_to_dev | output | 1 | Direction: 1 memory to device, 0 device to memory |
| rem_cnt | output | CW | Bytes still to move |
| done_o | output | 1 | Block finished |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the request and busy lines never overlap. They check that a tenure starts only after a free grant, that no grant leaks downstream while work is pending, and that each byte steps the remaining count by one. They also check that a steal-mode tenure never exceeds the burst limit, and that the interrupt appears only with done set. The bench scenarios are needed to show the totals that cross many cycles: the exact byte count and the address sequence, how a move splits into tenures in each mode, the masking and late unmasking of the interrupt, the zero-count start, and writes that are ignored while a move is in progress.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ARB_IDLE, ARB_REQ, ARB_OWN} arb_st_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  localparam int CTL_GO  = 0;
  localparam int CTL_IE  = 1;
  localparam int CTL_DIR = 2;
  localparam int CTL_BLK = 3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int WDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [WDW-1:0] cfg_wdata,
  input  logic           active,
  output logic           start_p,
  output logic [AW-1:0]  prog_addr,
  output logic [CW-1:0]  prog_cnt,
  output logic           ie,
  output logic           dir,
  output logic           blk
);
  logic wr_addr, wr_cnt, wr_ctl;

  assign wr_addr = cfg_we && cfg_sel == SEL_ADDR && !active;
  assign wr_cnt  = cfg_we && cfg_sel == SEL_CNT  && !active;
  assign wr_ctl  = cfg_we && cfg_sel == SEL_CTL;
  assign start_p = wr_ctl && cfg_wdata[CTL_GO] && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_cnt  <= '0;
      ie        <= 1'b0;
      dir       <= 1'b0;
      blk       <= 1'b0;
    end else begin
      if (wr_addr) prog_addr <= cfg_wdata[AW-1:0];
      if (wr_cnt)  prog_cnt  <= cfg_wdata[CW-1:0];
      if (wr_ctl) begin
        ie <= cfg_wdata[CTL_IE];
        if (!active) begin
          dir <= cfg_wdata[CTL_DIR];
          blk <= cfg_wdata[CTL_BLK];
        end
      end
    end
  end

  // R10
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> prog_cnt == $past(prog_cnt));
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_p,
  input  logic [AW-1:0] prog_addr,
  input  logic [CW-1:0] prog_cnt,
  input  logic          ie,
  input  logic          beat,
  output logic          active,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          last_byte,
  output logic          done,
  output logic          irq_o
);
  logic irq_pend;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_step(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  assign last_byte = cur_cnt == CW'(1);
  assign irq_o     = irq_pend && ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_addr <= '0;
      cur_cnt  <= '0;
      done     <= 1'b0;
      irq_pend <= 1'b0;
    end else if (start_p) begin
      cur_addr <= prog_addr;
      cur_cnt  <= prog_cnt;
      active   <= prog_cnt != '0;
      done     <= prog_cnt == '0;
      irq_pend <= prog_cnt == '0;
    end else if (beat) begin
      cur_addr <= addr_step(cur_addr);
      cur_cnt  <= cnt_step(cur_cnt);
      if (last_byte) begin
        active   <= 1'b0;
        done     <= 1'b1;
        irq_pend <= 1'b1;
      end
    end
  end

  // R3
  beat_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> active && cur_cnt != '0);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> cur_cnt == $past(cur_cnt) - CW'(1));
  // R8
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_pkg::*;
#(
  parameter int BURST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic last_byte,
  input  logic blk,
  input  logic bg_i,
  input  logic bbsy_i,
  output logic br_o,
  output logic bg_o,
  output logic bbsy_o,
  output logic beat
);
  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1;

  arb_st_e       st;
  logic [BW-1:0] burst_q;
  logic          bus_free, end_tenure;

  function automatic logic burst_full(input logic [BW-1:0] n, input logic block);
    return !block && (int'(n) == BURST - 1);
  endfunction

  assign bus_free   = bg_i && !bbsy_i;
  assign beat       = st == ARB_OWN;
  assign end_tenure = beat && (last_byte || burst_full(burst_q, blk));
  assign br_o       = st == ARB_REQ;
  assign bbsy_o     = st == ARB_OWN;
  assign bg_o       = bg_i && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ARB_IDLE;
      burst_q <= '0;
    end else begin
      unique case (st)
        ARB_IDLE: if (active) st <= ARB_REQ;
        ARB_REQ: if (bus_free) begin
          st      <= ARB_OWN;
          burst_q <= '0;
        end
        ARB_OWN: begin
          burst_q <= burst_q + BW'(1);
          if (end_tenure) st <= ARB_IDLE;
        end
        default: st <= ARB_IDLE;
      endcase
    end
  end

  // steal-mode run length counted independently of burst_q
  logic [7:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (bbsy_o) run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
    else             run_q <= '0;
  end

  // R4
  no_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_o && bbsy_o));
  // R4
  take_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bbsy_o) |-> $past(bg_i && !bbsy_i && br_o));
  // R5
  no_grant_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bg_o |-> !br_o && !bbsy_o);
  // R6
  burst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bbsy_o && !blk) |-> int'(run_q) < BURST);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int WDW   = 32,
  parameter int BURST = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [WDW-1:0] cfg_wdata,
  input  logic           bg_i,
  input  logic           bbsy_i,
  output logic           br_o,
  output logic           bg_o,
  output logic           bbsy_o,
  output logic           xfer_en,
  output logic [AW-1:0]  xfer_addr,
  output logic           xfer_to_dev,
  output logic [CW-1:0]  rem_cnt,
  output logic           done_o,
  output logic           irq_o
);
  logic          start_p, ie, dir, blk, active, last_byte, beat;
  logic [AW-1:0] prog_addr;
  logic [CW-1:0] prog_cnt;

  dma_regs #(.AW(AW), .CW(CW), .WDW(WDW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .active,
    .start_p, .prog_addr, .prog_cnt, .ie, .dir, .blk
  );

  dma_xfer #(.AW(AW), .CW(CW)) u_xfer (
    .clk, .rst_n, .start_p, .prog_addr, .prog_cnt, .ie, .beat,
    .active, .cur_addr(xfer_addr), .cur_cnt(rem_cnt), .last_byte,
    .done(done_o), .irq_o
  );

  dma_arb #(.BURST(BURST)) u_arb (
    .clk, .rst_n, .active, .last_byte, .blk, .bg_i, .bbsy_i,
    .br_o, .bg_o, .bbsy_o, .beat
  );

  assign xfer_en     = beat;
  assign xfer_to_dev = dir;

  // R4
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bbsy_o) |-> !$past(bbsy_i));
endmodule

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        bg_i = 1'b0;
  logic        bbsy_i = 1'b0;
  logic        br_o, bg_o, bbsy_o, xfer_en, xfer_to_dev, done_o, irq_o;
  logic [15:0] xfer_addr, rem_cnt;

  int n_chk = 0, n_bad = 0;
  int bytes = 0, tenures = 0, run = 0, max_run = 0, addr_err = 0;
  logic [15:0] exp_addr = '0;
  logic prev_bbsy = 1'b0;

  dma_chan u_dma_chan (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .bg_i, .bbsy_i,
    .br_o, .bg_o, .bbsy_o, .xfer_en, .xfer_addr, .xfer_to_dev,
    .rem_cnt, .done_o, .irq_o
  );

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (xfer_en) begin
      if (xfer_addr != exp_addr) addr_err++;
      exp_addr = exp_addr + 16'd1;
      bytes++;
    end
    if (bbsy_o && !prev_bbsy) tenures++;
    if (bbsy_o) begin
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
    prev_bbsy = bbsy_o;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic mon_clear(input logic [15:0] a);
    bytes = 0; tenures = 0; max_run = 0; addr_err = 0; exp_addr = a;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
  endtask

  // ctrl bits: 0 go, 1 ie, 2 dir, 3 block
  task automatic t_reset();
    check("R1 br", br_o, 0);
    check("R1 bbsy", bbsy_o, 0);
    check("R1 xfer_en", xfer_en, 0);
    check("R1 done", done_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_block();
    bg_i = 1'b1;
    wr(2'd0, 32'h0100);
    wr(2'd1, 32'd10);
    mon_clear(16'h0100);
    wr(2'd2, 32'b1111);
    wait_done();
    @(negedge clk);
    check("R3 bytes", bytes, 10);
    check("R3 addr seq", addr_err, 0);
    check("R3 rem_cnt", rem_cnt, 0);
    check("R7 tenures", tenures, 1);
    check("R7 run", max_run, 10);
    check("R2 dir", xfer_to_dev, 1);
    check("R8 done", done_o, 1);
    check("R8 irq", irq_o, 1);
  endtask

  task automatic t_steal();
    bg_i = 1'b1;
    wr(2'd0, 32'h0200);
    wr(2'd1, 32'd10);
    mon_clear(16'h0200);
    wr(2'd2, 32'b0011);
    check("R9 start clears done", done_o, 0);
    check("R9 start clears irq", irq_o, 0);
    wait_done();
    @(negedge clk);
    check("R6 bytes", bytes, 10);
    check("R6 tenures", tenures, 3);
    check("R6 max run", max_run, 4);
    check("R3 addr seq", addr_err, 0);
    check("R2 dir dev-to-mem", xfer_to_dev, 0);
  endtask

  task automatic t_grant();
    bg_i = 1'b1;
    @(negedge clk);
    check("R5 pass idle", bg_o, 1);
    bg_i = 1'b0;
    wr(2'd0, 32'h0300);
    wr(2'd1, 32'd3);
    mon_clear(16'h0300);
    wr(2'd2, 32'b1001);
    @(negedge clk); @(negedge clk);
    check("R4 request", br_o, 1);
    bg_i = 1'b1; bbsy_i = 1'b1;
    @(negedge clk);
    check("R5 no pass pending", bg_o, 0);
    @(negedge clk); @(negedge clk);
    check("R4 wait busy", bbsy_o, 0);
    check("R4 still req", br_o, 1);
    bbsy_i = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R4 owns", bbsy_o, 1);
    check("R4 br dropped", br_o, 0);
    wait_done();
    @(negedge clk);
    check("R4 bytes", bytes, 3);
    check("R5 pass after done", bg_o, 1);
  endtask

  task automatic t_mask();
    bg_i = 1'b1;
    wr(2'd0, 32'h0400);
    wr(2'd1, 32'd5);
    mon_clear(16'h0400);
    wr(2'd2, 32'b1001);
    wait_done();
    @(negedge clk);
    check("R8 done masked", done_o, 1);
    check("R8 irq masked", irq_o, 0);
    wr(2'd2, 32'b1010);
    check("R8 irq unmasked", irq_o, 1);
  endtask

  task automatic t_zero();
    bg_i = 1'b1;
    wr(2'd1, 32'd0);
    mon_clear(16'h0400);
    wr(2'd2, 32'b0011);
    check("R9 zero done", done_o, 1);
    check("R9 zero irq", irq_o, 1);
    repeat (5) @(negedge clk);
    check("R9 zero bytes", bytes, 0);
    check("R9 zero no busy", tenures, 0);
  endtask

  task automatic t_ignore();
    bg_i = 1'b0;
    wr(2'd0, 32'h0500);
    wr(2'd1, 32'd6);
    mon_clear(16'h0500);
    wr(2'd2, 32'b1011);
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h0900);
    wr(2'd2, 32'b1011);
    check("R10 rem kept", rem_cnt, 6);
    bg_i = 1'b1;
    wait_done();
    @(negedge clk);
    check("R10 bytes", bytes, 6);
    check("R10 addr seq", addr_err, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_block();
    t_steal();
    t_grant();
    t_mask();
    t_zero();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule